// File: doc/BRIEF.md
# Dual-Image Boot Selector with Windowed Address Remap

This block sits between a boot sequencer and a flash read port. After reset it reads a header word from each of two firmware images: image 0 at the bottom of flash and image 1 at a configured offset. Each header word may carry a version number, and the block uses the versions to decide which image to try first. The caller runs the chosen image and then reports whether it came up. On a failure report the block switches to the other image. If the second image also fails, the block raises a sticky failure flag.

While image 1 is the active candidate, the block relocates flash accesses. The caller's access address has the configured offset added to it whenever the address lies below the configured window size. Addresses at or above the window size pass through unchanged. While image 0 is active, no address is changed.

Top module: `dual_image_boot_sel`

## Requirements
- R1: After reset the block presents a header read at byte address 0x24 on the flash port, and holds selValid, remapEn and bootFail low.
- R2: Header reads are strictly serial. The read of image 0 at 0x24 is held until a response is seen. Only then is the read of image 1 at cfgOffset+0x24 presented, and it is also held until its response.
- R3: A header word yields a version only when its bit 10 is 1, in which case the version is bits [31:16]. With bit 10 at 0 the version is taken as 0. For example 0x10400 gives 1, 0x30400 gives 3 and 0xFFFF0000 gives 0.
- R4: The image with the strictly higher version is chosen first. On equal versions image 0 is chosen. selImage is 0 for image 0 and 1 for image 1.
- R5: selValid rises exactly two clock edges after the edge that samples the image 1 header response, and stays high while an image is being tried or has booted.
- R6: A failure report (statusValid high with statusOk low) while the first choice is being tried switches selImage to the other image on the next edge.
- R7: A success report (statusValid and statusOk high) freezes the selection. Later status reports and flash responses leave selImage, selValid and bootFail unchanged.
- R8: A failure report while the second image is being tried raises bootFail and drops selValid and remapEn. These hold until reset, whatever status arrives afterwards.
- R9: remapEn is high exactly while image 1 is the selected candidate. When it is high, an access address below cfgSize is sent as accAddr+cfgOffset (modulo the address width). Addresses at or above cfgSize, and all addresses while remapEn is low, are sent unchanged.
- R10: Before a selection exists, status reports and caller accesses have no effect. During the two header reads the flash port carries only the header reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgOffset | input | ADDR_W | Base address of image 1 and relocation offset |
| cfgSize | input | ADDR_W | Size of the relocation window |
| flReqValid | output | 1 | Flash read request valid |
| flReqAddr | output | ADDR_W | Flash read byte address |
| flRspValid | input | 1 | Flash read data valid |
| flRspData | input | DATA_W | Flash read data |
| accValid | input | 1 | Caller access request valid |
| accAddr | input | ADDR_W | Caller access byte address before relocation |
| statusValid | input | 1 | Boot outcome report strobe |
| statusOk | input | 1 | Boot outcome: 1 success, 0 failure |
| selValid | output | 1 | An image is being tried or has booted |
| selImage | output | 1 | Selected image index |
| remapEn | output | 1 | Address relocation active |
| bootFail | output | 1 | Both images failed (sticky) |

## Verification
The bench targets four kinds of error:
- Version ties and headers whose presence bit is clear. A design that mishandled these would boot the older image, or would trust a stale version field.
- The exact window boundary, probed at cfgSize-1 and at cfgSize. An off-by-one compare would relocate one address too many or one too few.
- The full fail-fail path, followed by a late success report. A design with a non-sticky failure flag, or one that keeps remapping after giving up, shows up here.
- Status pulses and caller accesses injected during the header reads, with response latencies varied. Premature state changes, and accesses leaking onto the flash port during the reads, would be exposed.

// File: rtl/dib_pkg.sv
package dib_pkg;

  typedef enum logic [2:0] {
    ST_HDR0,
    ST_HDR1,
    ST_PICK,
    ST_TRY_A,
    ST_TRY_B,
    ST_LIVE,
    ST_DEAD
  } bootState_t;

  typedef struct packed {
    logic hdrPhase;   // a header read owns the flash port
    logic hdrIdx;     // which image header is being read
    logic capHdr;     // header response arrives this cycle
    logic pickFirst;  // latch the first-choice image
    logic swapImg;    // switch to the other image
    logic selValid;   // a candidate image is active
  } ctrlStrobe_t;

endpackage

// File: rtl/dib_ctrl.sv
module dib_ctrl
  import dib_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flRspValid,
  input  logic        statusValid,
  input  logic        statusOk,
  output ctrlStrobe_t strb,
  output logic        bootFail
);

  bootState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HDR0;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_HDR0:  if (flRspValid) stateNxt = ST_HDR1;
      ST_HDR1:  if (flRspValid) stateNxt = ST_PICK;
      ST_PICK:  stateNxt = ST_TRY_A;
      ST_TRY_A: if (statusValid) stateNxt = statusOk ? ST_LIVE : ST_TRY_B;
      ST_TRY_B: if (statusValid) stateNxt = statusOk ? ST_LIVE : ST_DEAD;
      ST_LIVE:  stateNxt = ST_LIVE;
      ST_DEAD:  stateNxt = ST_DEAD;
      default:  stateNxt = ST_HDR0;
    endcase
  end

  always_comb begin
    strb           = '0;
    strb.hdrPhase  = (state == ST_HDR0) || (state == ST_HDR1);
    strb.hdrIdx    = (state == ST_HDR1);
    strb.capHdr    = strb.hdrPhase && flRspValid;
    strb.pickFirst = (state == ST_PICK);
    strb.swapImg   = (state == ST_TRY_A) && statusValid && !statusOk;
    strb.selValid  = (state == ST_TRY_A) || (state == ST_TRY_B) || (state == ST_LIVE);
  end

  assign bootFail = (state == ST_DEAD);

  AST_HDR_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HDR0 && !flRspValid) |=> (state == ST_HDR0)); // R2

  AST_HDR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HDR1 && !flRspValid) |=> (state == ST_HDR1)); // R2

  AST_EARLY_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HDR0 || state == ST_HDR1 || state == ST_PICK)
      |=> !(state == ST_LIVE || state == ST_DEAD || state == ST_TRY_B)); // R10

  AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEAD) |=> (state == ST_DEAD)); // R8

endmodule

// File: rtl/dib_datapath.sv
module dib_datapath
  import dib_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 32,
  parameter int HDR_OFF  = 'h24,
  parameter int FLAG_BIT = 10,
  parameter int VER_LSB  = 16,
  parameter int VER_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] cfgOffset,
  input  logic [ADDR_W-1:0] cfgSize,
  input  logic [DATA_W-1:0] rspData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              flReqValid,
  output logic [ADDR_W-1:0] flReqAddr,
  output logic              selImage,
  output logic              remapEn
);

  localparam int NUM_IMG = 2;
  localparam logic [ADDR_W-1:0] HDR_ADDR = ADDR_W'(HDR_OFF);

  logic [VER_W-1:0] verReg [NUM_IMG];
  logic             unusedHdrBits;

  assign unusedHdrBits = ^rspData;

  for (genvar g = 0; g < NUM_IMG; g++) begin : gImgVer
    always_ff @(posedge clk) begin
      if (!rstN) begin
        verReg[g] <= '0;
      end else if (strb.capHdr && (strb.hdrIdx == 1'(g))) begin
        verReg[g] <= rspData[FLAG_BIT] ? rspData[VER_LSB +: VER_W] : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               selImage <= 1'b0;
    else if (strb.pickFirst) selImage <= (verReg[1] > verReg[0]);
    else if (strb.swapImg)   selImage <= ~selImage;
  end

  assign remapEn = strb.selValid && selImage;

  logic [ADDR_W-1:0] hdrAddr;
  logic [ADDR_W-1:0] accOut;
  logic              inWindow;

  assign hdrAddr  = strb.hdrIdx ? (cfgOffset + HDR_ADDR) : HDR_ADDR;
  assign inWindow = (accAddr < cfgSize);
  assign accOut   = (remapEn && inWindow) ? (accAddr + cfgOffset) : accAddr;

  assign flReqValid = strb.hdrPhase ? 1'b1 : accValid;
  assign flReqAddr  = strb.hdrPhase ? hdrAddr : accOut;

  AST_SWAP_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.swapImg |=> (selImage != $past(selImage))); // R6

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.pickFirst && !strb.swapImg) |=> $stable(selImage)); // R7

  AST_PASS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.hdrPhase && accValid && accAddr >= cfgSize) |-> (flReqAddr == accAddr)); // R9

endmodule

// File: rtl/dual_image_boot_sel.sv
module dual_image_boot_sel
  import dib_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 32,
  parameter int HDR_OFF  = 'h24,
  parameter int FLAG_BIT = 10,
  parameter int VER_LSB  = 16,
  parameter int VER_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgOffset,
  input  logic [ADDR_W-1:0] cfgSize,
  output logic              flReqValid,
  output logic [ADDR_W-1:0] flReqAddr,
  input  logic              flRspValid,
  input  logic [DATA_W-1:0] flRspData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              statusValid,
  input  logic              statusOk,
  output logic              selValid,
  output logic              selImage,
  output logic              remapEn,
  output logic              bootFail
);

  ctrlStrobe_t strb;

  dib_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .flRspValid  (flRspValid),
    .statusValid (statusValid),
    .statusOk    (statusOk),
    .strb        (strb),
    .bootFail    (bootFail)
  );

  dib_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .HDR_OFF  (HDR_OFF),
    .FLAG_BIT (FLAG_BIT),
    .VER_LSB  (VER_LSB),
    .VER_W    (VER_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgOffset  (cfgOffset),
    .cfgSize    (cfgSize),
    .rspData    (flRspData),
    .accValid   (accValid),
    .accAddr    (accAddr),
    .flReqValid (flReqValid),
    .flReqAddr  (flReqAddr),
    .selImage   (selImage),
    .remapEn    (remapEn)
  );

  assign selValid = strb.selValid;

  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    bootFail |-> (!selValid && !remapEn)); // R8

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    bootFail |=> bootFail); // R8

endmodule

// File: tb/test_dual_image_boot_sel.sv
`timescale 1ns/1ps
module test_dual_image_boot_sel;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int MASK   = (1 << ADDR_W) - 1;
  localparam int OFFS   = 'h20000;
  localparam int WSIZE  = 'h1D800;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] cfgOffset = ADDR_W'(OFFS);
  logic [ADDR_W-1:0] cfgSize   = ADDR_W'(WSIZE);
  logic              flReqValid;
  logic [ADDR_W-1:0] flReqAddr;
  logic              flRspValid = 1'b0;
  logic [DATA_W-1:0] flRspData  = '0;
  logic              accValid = 1'b0;
  logic [ADDR_W-1:0] accAddr  = '0;
  logic              statusValid = 1'b0;
  logic              statusOk    = 1'b0;
  logic              selValid, selImage, remapEn, bootFail;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk;

  dual_image_boot_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dual_image_boot_sel (
    .clk(clk), .rstN(rstN), .cfgOffset(cfgOffset), .cfgSize(cfgSize),
    .flReqValid(flReqValid), .flReqAddr(flReqAddr),
    .flRspValid(flRspValid), .flRspData(flRspData),
    .accValid(accValid), .accAddr(accAddr),
    .statusValid(statusValid), .statusOk(statusOk),
    .selValid(selValid), .selImage(selImage), .remapEn(remapEn), .bootFail(bootFail)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int verOf(input logic [31:0] h);
    return h[10] ? int'(h[31:16]) : 0;
  endfunction

  // Behavioural reference: phase 0/1 header reads, 2 choosing, 3 first try,
  // 4 second try, 5 booted, 6 given up
  int mPhase = 0;
  int mV0 = 0, mV1 = 0, mSel = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mSel = 0; mV0 = 0; mV1 = 0;
    end else begin
      case (mPhase)
        0: if (flRspValid) begin mV0 = verOf(flRspData); mPhase = 1; end
        1: if (flRspValid) begin mV1 = verOf(flRspData); mPhase = 2; end
        2: begin mSel = (mV1 > mV0) ? 1 : 0; mPhase = 3; end
        3: if (statusValid) begin
             if (statusOk) mPhase = 5;
             else begin mSel = 1 - mSel; mPhase = 4; end
           end
        4: if (statusValid) mPhase = statusOk ? 5 : 6;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      bit remapOn;
      bit expVal;
      int expAddr;
      remapOn = (mPhase >= 3 && mPhase <= 5) && (mSel == 1);
      expVal  = (mPhase < 2) ? 1'b1 : accValid;
      chk(flReqValid == expVal, (mPhase < 2) ? "R2 reqValid" : "R10 reqValid", flReqValid, expVal);
      if (expVal) begin
        if (mPhase == 0)      expAddr = 'h24;
        else if (mPhase == 1) expAddr = (OFFS + 'h24) & MASK;
        else if (remapOn && int'(accAddr) < WSIZE) expAddr = (int'(accAddr) + OFFS) & MASK;
        else                  expAddr = int'(accAddr);
        chk(int'(flReqAddr) == expAddr, (mPhase < 2) ? "R2 reqAddr" : "R9 reqAddr", flReqAddr, expAddr);
      end
      chk(selValid == (mPhase >= 3 && mPhase <= 5), "R5 selValid", selValid, (mPhase >= 3 && mPhase <= 5));
      chk(remapEn == remapOn, "R9 remapEn", remapEn, remapOn);
      chk(bootFail == (mPhase == 6), "R8 bootFail", bootFail, (mPhase == 6));
      if (mPhase >= 3 && mPhase <= 5)
        chk(selImage == 1'(mSel), (mPhase == 4) ? "R6 selImage" : "R4 selImage", selImage, mSel);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Reset, run both header reads with given latencies, stop once the first choice is live
  task automatic startBoot(input logic [31:0] h0, input logic [31:0] h1, input int lat0, input int lat1);
    rstN = 1'b0; flRspValid = 1'b0; accValid = 1'b0; statusValid = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    @(negedge clk);
    chk(flReqValid && flReqAddr == 'h24 && !selValid && !remapEn && !bootFail,
        "R1 reset state", flReqAddr, 'h24);
    for (int i = 0; i < lat0; i++) begin
      accValid = 1'b1; accAddr = ADDR_W'('h1234);
      statusValid = 1'b1; statusOk = i[0];
      tick();
    end
    accValid = 1'b0; statusValid = 1'b0;
    flRspValid = 1'b1; flRspData = h0;
    tick();
    flRspValid = 1'b0;
    for (int i = 0; i < lat1; i++) begin
      statusValid = 1'b1; statusOk = 1'b0;
      tick();
    end
    statusValid = 1'b0;
    flRspValid = 1'b1; flRspData = h1;
    tick();
    flRspValid = 1'b0;
    @(negedge clk);
    chk(!selValid, "R5 not yet valid", selValid, 0);
    tick();
    @(negedge clk);
    chk(selValid && selImage == ((verOf(h1) > verOf(h0)) ? 1'b1 : 1'b0),
        "R4 first choice", selImage, (verOf(h1) > verOf(h0)));
  endtask

  task automatic report(input bit ok);
    statusValid = 1'b1; statusOk = ok;
    tick();
    statusValid = 1'b0;
  endtask

  task automatic access(input int a, input int exp, input string tag);
    accValid = 1'b1; accAddr = ADDR_W'(a);
    @(negedge clk);
    chk(int'(flReqAddr) == exp, tag, flReqAddr, exp);
    tick();
    accValid = 1'b0;
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    tick();
    // Newer image 1, window edges, success then ignored report
    startBoot(32'h0001_0400, 32'h0002_0400, 0, 2);
    chk(remapEn, "R9 remap on image1", remapEn, 1);
    access('h0, 'h20000, "R9 low address offset");
    access('h1D7FF, 'h3D7FF, "R9 last in-window address");
    access('h1D800, 'h1D800, "R9 size boundary passes");
    report(1'b1);
    report(1'b0);
    flRspValid = 1'b1; flRspData = 32'hFFFF_0400; tick(); flRspValid = 1'b0;
    @(negedge clk);
    chk(selValid && selImage && !bootFail, "R7 frozen after success", selImage, 1);

    // Older image 1: fallback, then both fail, then late success ignored
    startBoot(32'h0003_0400, 32'h0002_0400, 3, 0);
    access('h100, 'h100, "R9 no offset for image0");
    report(1'b0);
    @(negedge clk);
    chk(selImage && remapEn, "R6 fallback to image1", selImage, 1);
    flRspValid = 1'b1; tick(); flRspValid = 1'b0;
    report(1'b0);
    @(negedge clk);
    chk(bootFail && !selValid && !remapEn, "R8 both failed", bootFail, 1);
    report(1'b1);
    access('h0, 'h0, "R8 no remap after failure");
    @(negedge clk);
    chk(bootFail, "R8 sticky", bootFail, 1);

    // Equal versions choose image 0
    startBoot(32'h0002_0400, 32'h0002_0400, 1, 1);
    chk(!selImage, "R4 tie picks image0", selImage, 0);

    // Presence flag clear means version 0
    startBoot(32'hFFFF_0000, 32'h0001_0400, 0, 0);
    chk(selImage, "R3 absent version on image0", selImage, 1);
    startBoot(32'h0001_0400, 32'h7FFF_0000, 2, 1);
    chk(!selImage, "R3 absent version on image1", selImage, 0);

    // Fallback from image1 to image0, then success
    startBoot(32'h0001_0400, 32'h0002_0400, 1, 0);
    report(1'b0);
    @(negedge clk);
    chk(!selImage && !remapEn, "R6 fallback to image0", selImage, 0);
    report(1'b1);
    report(1'b0);
    @(negedge clk);
    chk(selValid && !selImage && !bootFail, "R7 success on second try", selImage, 0);

    repeat (3) tick();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule